// File: doc/BRIEF.md
# MDIO Management Master

This block is a management master for Ethernet PHYs. It sits on a simple 32-bit register bus and drives the two-wire management interface: a clock output (`mdc`) and a bidirectional data line. The data line is split into `mdio_o`, `mdio_oe` and `mdio_i`. A write to a register is what starts a bus transaction, so software needs no separate "go" bit. It writes a target, starts the frame, and then polls a busy flag.

A configuration bit chooses between two frame encodings. The basic encoding carries a 5-bit register number. The extended encoding carries a 5-bit device address and uses separate address and data frames. Every frame has 64 bits: a preamble of 32 ones, two start bits, two opcode bits, the PHY address, the register or device field, two turnaround bits, and 16 data bits. A read frame releases the line from the turnaround onward and captures the PHY's reply. If the PHY does not pull the second turnaround bit low, the read is flagged as failed and reads back as all ones.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, busy is 0, `mdc` is low, `mdio_oe` is 0, and the status (0x30), control (0x34), data (0x38) and address (0x3c) registers all read 0.
- R2: Bit 6 of the word at 0x30 is writable and reads back; 1 selects extended frames and 0 selects basic frames. Bit 31 reads as busy and bit 1 reads as the read-error flag.
- R3: A write to 0x34 with bit 15 set starts a read frame whose target is PHY address bits 9:5 and register/device bits 4:0 of that write. A basic read has start bits 01 and opcode 10. A write to 0x34 with bit 15 clear only stores the value and starts nothing.
- R4: A write to 0x38 stores the data and starts a write frame to the stored target. The frame is 32 ones, start 01 (basic), opcode 01, 5-bit PHY address, 5-bit register, turnaround 10, then 16 data bits. Every field is sent MSB first.
- R5: In extended mode every frame has start 00 and uses opcode 00 for an address frame, 01 for a write and 11 for a read. A write to 0x3c stores the 16-bit register address and, in extended mode only, sends it in an address frame carrying the stored PHY and device address. In basic mode the write to 0x3c is stored and no frame starts.
- R6: During a read frame `mdio_oe` is 1 for the first 46 bits and 0 for the last 18 bits. The 16 bits sampled after the turnaround are returned at 0x38 in bits 15:0, with bits 31:16 zero.
- R7: If `mdio_i` is high when the second turnaround bit of a read is sampled, bit 1 of 0x30 is set at the end of the frame and 0x38 reads 0xFFFF. The next read with a good turnaround clears bit 1.
- R8: The `mdc` period is 2*DIV system clocks. `mdio_o` changes only while `mdc` is low, and input bits are sampled on the `mdc` rising edge. While idle, `mdc` stays low and `mdio_oe` stays 0.
- R9: Busy is set from the start of a frame until its last bit, with exactly 64 `mdc` rising edges in a frame. A frame-starting write (0x38, 0x3c, or 0x34 with bit 15) made while busy is ignored: it changes no register and starts no frame.
- R10: 0x34 reads back bits 15:0 as last accepted, 0x3c reads back the stored address, and all unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register byte offset |
| wdata | input | 16 | Write data (low half of the 32-bit register) |
| rdata | output | 32 | Read data for `addr`, combinational |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Serial data driven onto the line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Serial data sampled from the line |

## Verification
Some rules are checked by the embedded assertions on every cycle:
- the clock and drive enable stay quiet while idle;
- `mdio_o` changes only during the low half of `mdc`;
- each frame opens with a driven one;
- a data write made during a write frame leaves the data register alone;
- the error flag moves only when the frame has ended.

Other rules can only be shown by the bench scenarios, which capture whole frames on the `mdc` rising edges and compare them with bit patterns built arithmetically:
- the exact start and opcode values in both encodings;
- the field order and values across swept PHY and register addresses;
- the read data capture and the error path;
- the rule that a launch made while busy starts no second frame.

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master #(
  parameter int DIV = 4,
  parameter int AW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   wdata,
  output logic [31:0]   rdata,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i
);
  localparam int CW = $clog2(DIV + 1);
  localparam logic [CW-1:0] CMAX = CW'(DIV - 1);
  localparam logic [AW-1:0] A_CFG = AW'(8'h30);
  localparam logic [AW-1:0] A_CTL = AW'(8'h34);
  localparam logic [AW-1:0] A_DAT = AW'(8'h38);
  localparam logic [AW-1:0] A_ADR = AW'(8'h3c);

  logic          ext, rd_err, busy, is_rd, ta_bad;
  logic [15:0]   ctl_q, data_q, addr_q, rx;
  logic [63:0]   sh;
  logic [5:0]    idx;
  logic [CW-1:0] cnt;

  wire hit_ctl = wr_en && addr == A_CTL;
  wire launch_rd = hit_ctl && wdata[15] && !busy;
  wire launch_wr = wr_en && addr == A_DAT && !busy;
  wire launch_ad = wr_en && addr == A_ADR && ext && !busy;
  wire launch = launch_rd || launch_wr || launch_ad;
  wire tick = busy && cnt == CMAX;
  wire rise = tick && !mdc;
  wire fall = tick && mdc;

  logic [1:0]  op_n;
  logic [9:0]  tgt_n;
  logic [15:0] pay_n;
  always_comb begin
    op_n  = 2'b01;
    tgt_n = ctl_q[9:0];
    pay_n = wdata;
    if (launch_rd) begin
      op_n  = ext ? 2'b11 : 2'b10;
      tgt_n = wdata[9:0];
      pay_n = 16'hFFFF;
    end else if (launch_ad) begin
      op_n = 2'b00;
    end
  end
  wire [63:0] sh_n = {32'hFFFF_FFFF, ext ? 2'b00 : 2'b01, op_n, tgt_n, 2'b10, pay_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext <= 1'b0; rd_err <= 1'b0; busy <= 1'b0; is_rd <= 1'b0; ta_bad <= 1'b0;
      ctl_q <= '0; data_q <= '0; addr_q <= '0; rx <= '0;
      sh <= '0; idx <= '0; cnt <= '0; mdc <= 1'b0;
    end else begin
      if (wr_en && addr == A_CFG) ext <= wdata[6];
      if (hit_ctl && (!wdata[15] || !busy)) ctl_q <= wdata;
      if (wr_en && addr == A_ADR && !busy) addr_q <= wdata;
      if (launch) begin
        busy <= 1'b1; sh <= sh_n; idx <= '0; cnt <= '0; mdc <= 1'b0;
        is_rd <= launch_rd; ta_bad <= 1'b0;
        if (launch_wr) data_q <= wdata;
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) mdc <= ~mdc;
        if (rise && is_rd) begin
          if (idx == 6'd47) ta_bad <= mdio_i;
          if (idx >= 6'd48) rx <= {rx[14:0], mdio_i};
        end
        if (fall) begin
          if (idx == 6'd63) begin
            busy <= 1'b0;
            if (is_rd) begin
              rd_err <= ta_bad;
              data_q <= ta_bad ? 16'hFFFF : rx;
            end
          end else begin
            idx <= idx + 6'd1;
            sh  <= {sh[62:0], 1'b0};
          end
        end
      end
    end
  end

  assign mdio_o  = sh[63];
  assign mdio_oe = busy && !(is_rd && idx >= 6'd46);

  always_comb begin
    case (addr)
      A_CFG:   rdata = {busy, 24'b0, ext, 4'b0, rd_err, 1'b0};
      A_CTL:   rdata = {16'b0, ctl_q};
      A_DAT:   rdata = {16'b0, data_q};
      A_ADR:   rdata = {16'b0, addr_q};
      default: rdata = '0;
    endcase
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mdc && !mdio_oe); // R8
  AST_EDGE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) busy && !$stable(mdio_o) |-> !mdc); // R8
  AST_PREAMBLE_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> mdio_oe && mdio_o); // R4
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy && !is_rd && wr_en && addr == A_DAT |=> $stable(data_q)); // R9
  AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n) !$stable(rd_err) |-> !busy); // R7
endmodule

// File: tb/sim_mdio_mgmt_master.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_master;
  localparam int CLK_NS = 10;
  localparam int DIV = 2;
  localparam int AW = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, mdio_i = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [31:0] rdata;
  logic mdc, mdio_o, mdio_oe;
  int checks = 0, errors = 0;

  mdio_mgmt_master #(.DIV(DIV), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bw(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic br(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  function automatic logic [63:0] frm(logic [1:0] st, logic [1:0] op, logic [4:0] p,
                                      logic [4:0] r, logic [1:0] ta, logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, p, r, ta, d};
  endfunction

  task automatic run_frame(input logic [63:0] resp, output logic [63:0] bits,
                           output logic [63:0] oes, output realtime per);
    realtime t0;
    logic [31:0] s;
    t0 = 0; per = 0;
    for (int k = 0; k < 64; k++) begin
      mdio_i = resp[63-k];
      @(posedge mdc);
      if (k == 0) t0 = $realtime;
      if (k == 1) per = $realtime - t0;
      #1;
      bits[63-k] = mdio_o;
      oes[63-k] = mdio_oe;
    end
    s = 32'hFFFF_FFFF;
    for (int n = 0; n < 50; n++) begin
      br(8'h30, s);
      if (!s[31]) break;
    end
    mdio_i = 1'b1;
    chk("R9 busy cleared after 64 bits", {63'b0, s[31]}, 64'd0);
  endtask

  task automatic do_read(input logic ext, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d, input logic bad);
    logic [63:0] bits, oes, exp;
    logic [31:0] v;
    realtime per;
    bw(8'h34, {1'b1, 5'b0, p, r});
    run_frame({46'h3FFF_FFFF_FFFF, 1'b1, bad, d}, bits, oes, per);
    exp = frm(ext ? 2'b00 : 2'b01, ext ? 2'b11 : 2'b10, p, r, 2'b10, 16'h0);
    chk(ext ? "R5 extended read header" : "R3 basic read header", {18'b0, bits[63:18]}, {18'b0, exp[63:18]});
    chk("R6 read release pattern", oes, {46'h3FFF_FFFF_FFFF, 18'b0});
    br(8'h38, v);
    chk(bad ? "R7 error data all ones" : "R6 read data", {32'b0, v}, bad ? 64'hFFFF : {48'b0, d});
    br(8'h30, v);
    chk("R7 read error flag", {63'b0, v[1]}, {63'b0, bad});
  endtask

  task automatic do_write(input logic ext, input logic [4:0] p, input logic [4:0] r,
                          input logic [15:0] d);
    logic [63:0] bits, oes;
    logic [31:0] v;
    realtime per;
    bw(8'h34, {6'b0, p, r});
    bw(8'h38, d);
    br(8'h30, v);
    chk("R9 busy set after launch", {63'b0, v[31]}, 64'd1);
    run_frame(64'hFFFF_FFFF_FFFF_FFFF, bits, oes, per);
    chk(ext ? "R5 extended write frame" : "R4 basic write frame", bits,
        frm(ext ? 2'b00 : 2'b01, 2'b01, p, r, 2'b10, d));
    chk("R4 write frame fully driven", oes, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R8 mdc period", 64'(int'(per)), 64'(2 * DIV * CLK_NS));
    br(8'h38, v);
    chk("R10 data readback", {32'b0, v}, {48'b0, d});
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++; checks++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [63:0] bits, oes;
    realtime per;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 mdc/oe at reset", {62'b0, mdc, mdio_oe}, 64'd0);
    br(8'h30, v); chk("R1 status reset", {32'b0, v}, 64'd0);
    br(8'h34, v); chk("R1 control reset", {32'b0, v}, 64'd0);
    br(8'h38, v); chk("R1 data reset", {32'b0, v}, 64'd0);
    br(8'h3c, v); chk("R1 address reset", {32'b0, v}, 64'd0);
    // R2 config bit
    bw(8'h30, 16'h0040); br(8'h30, v); chk("R2 extended select readback", {32'b0, v}, 64'h40);
    bw(8'h30, 16'h0000); br(8'h30, v); chk("R2 basic select readback", {32'b0, v}, 64'h0);
    // R3 control write without read bit starts nothing
    bw(8'h34, 16'h7ABC);
    repeat (20) @(negedge clk);
    chk("R3 no frame from plain control write", {62'b0, mdc, mdio_oe}, 64'd0);
    br(8'h30, v); chk("R3 busy stays clear", {63'b0, v[31]}, 64'd0);
    br(8'h34, v); chk("R10 control readback", {32'b0, v}, 64'h7ABC);
    // R4 basic write sweep
    for (int p = 0; p < 32; p += 3)
      do_write(1'b0, 5'(p), 5'((p * 7 + 3) % 32), 16'((p * 2053 + 17) % 65536));
    // R3 R6 basic read sweep
    for (int p = 1; p < 32; p += 4)
      do_read(1'b0, 5'(p), 5'(31 - p), 16'((p * 4099 + 3) % 65536), 1'b0);
    // R7 error then recovery
    do_read(1'b0, 5'd9, 5'd2, 16'h1234, 1'b1);
    do_read(1'b0, 5'd9, 5'd2, 16'h0F0F, 1'b0);
    // R5 basic mode address write: stored, no frame
    bw(8'h3c, 16'hBEEF);
    repeat (20) @(negedge clk);
    chk("R5 no address frame in basic mode", {62'b0, mdc, mdio_oe}, 64'd0);
    br(8'h3c, v); chk("R10 address readback", {32'b0, v}, 64'hBEEF);
    // R5 extended frames
    bw(8'h30, 16'h0040);
    for (int p = 2; p < 32; p += 7) begin
      bw(8'h34, {6'b0, 5'(p), 5'(p + 1)});
      bw(8'h3c, 16'((p * 3001) % 65536));
      run_frame(64'hFFFF_FFFF_FFFF_FFFF, bits, oes, per);
      chk("R5 extended address frame", bits,
          frm(2'b00, 2'b00, 5'(p), 5'(p + 1), 2'b10, 16'((p * 3001) % 65536)));
      do_write(1'b1, 5'(p), 5'(p + 1), 16'((p * 577) % 65536));
      do_read(1'b1, 5'(p), 5'(p + 1), 16'((p * 911 + 5) % 65536), 1'b0);
    end
    do_read(1'b1, 5'd4, 5'd1, 16'h5555, 1'b1);
    bw(8'h30, 16'h0000);
    // R9 launches while busy are ignored
    bw(8'h34, {6'b0, 5'd3, 5'd12});
    bw(8'h38, 16'hA5C3);
    fork
      run_frame(64'hFFFF_FFFF_FFFF_FFFF, bits, oes, per);
      begin
        repeat (20) @(negedge clk);
        bw(8'h38, 16'h1111);
        bw(8'h34, 16'h8000);
      end
    join
    chk("R9 in-flight frame unchanged", bits, frm(2'b01, 2'b01, 5'd3, 5'd12, 2'b10, 16'hA5C3));
    br(8'h38, v); chk("R9 data not overwritten while busy", {32'b0, v}, 64'hA5C3);
    br(8'h34, v); chk("R9 control not overwritten while busy", {32'b0, v}, 64'h006C);
    repeat (40) @(negedge clk);
    chk("R9 no second frame", {62'b0, mdc, mdio_oe}, 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule